// File: doc/BRIEF.md
# Two-Channel Serial Register Access Unit

This block is the host-facing register unit of a two-channel serial controller. A byte-wide host bus reaches each channel through a control port and a data port. Each channel holds sixteen write registers and a small set of readable status registers. They are reached in two steps: a first control write loads a register pointer, and the next control access uses it. The pointer then falls back to zero by itself, so an access with the pointer at zero always reaches the command/status register.

The unit keeps the per-channel status bits: receive byte waiting, transmit buffer empty, all characters sent, and a sticky break flag. It latches one received byte per channel and forwards host data bytes to the transmitter when transmit is enabled. A field in write register 9 resets one channel or both. From the configuration registers it derives the line parameters: character length, parity, stop bits, clock prescale, the 16-bit baud time constant and the resulting bit period in input clocks. Bit-serial shifting is not part of this unit.

Top module: `serreg_top`

## Requirements
- R1: `bus_addr[0]` selects the port (0 = control, 1 = data), and `bus_addr[1]` selects the channel (0 or 1). An access to one channel leaves the other channel's registers unchanged.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. If data bits 5:3 equal 3'b001, the value 8 is added, so registers 8 to 15 can be reached.
- R3: A control read or control write made while the pointer is nonzero returns the pointer to 0. A control read returns the read register the pointer selects: 0 gives status, 1 gives the sent/format status, 12 and 13 give the time constant, and all others give 0.
- R4: A write to register 9 on either channel with data bits 7:6 = 01 resets channel 0, 10 resets channel 1, and 11 resets both. With 00, no channel is reset.
- R5: After reset, write register 4 = 0x04, 9 = 0xC0, 11 = 0x08, 14 = 0x30 and 15 = 0xF8, and every other write register is 0. Read register 0 = 0x44 and read register 1 = 0x07.
- R6: Values written to write registers 12 (low) and 13 (high) read back from read registers 12 and 13. They also appear as `time_const` = {WR13, WR12}.
- R7: A received byte is taken only when WR3 bit 0 is 1 and RR0 bit 0 is 0 (this is `rx_ready`). Taking a byte sets RR0 bit 0. A data-port read returns the byte held and clears RR0 bit 0.
- R8: A data-port write sets RR0 bit 2 and RR1 bit 0. In the next cycle `tx_valid` pulses with the byte, but only if WR5 bit 3 was 1.
- R9: The character length follows WR5 bits 6:5: 00 gives 5 bits, 01 gives 7, 10 gives 6 and 11 gives 8.
- R10: Parity is enabled by WR4 bit 0 and is even when WR4 bit 1 is 1. Two stop bits are selected only when WR4 bits 3:2 = 11.
- R11: WR4 bits 7:6 select a prescale of 1, 16, 32 or 64 (codes 00 to 11). The bit period is `bit_cycles` = 2 × (time_const + 2) × prescale input clocks.
- R12: A high `brk_in` sets RR0 bit 7. The bit stays set until its channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Bit 0 selects control/data, bit 1 selects the channel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the access is presented |
| rx_valid | input | 2 | Received byte strobe per channel |
| rx_byte | input | 16 | Received byte per channel (channel c in bits 8c+7:8c) |
| rx_ready | output | 2 | Channel can take a received byte |
| brk_in | input | 2 | Break detected per channel |
| tx_valid | output | 2 | Transmit byte strobe per channel |
| tx_byte | output | 16 | Transmit byte per channel |
| char_len | output | 8 | Character length in bits, 4 bits per channel |
| par_en | output | 2 | Parity enable per channel |
| par_even | output | 2 | Even parity per channel |
| stop2 | output | 2 | Two stop bits per channel |
| prescale | output | 14 | Clock prescale (1/16/32/64), 7 bits per channel |
| time_const | output | 32 | Baud time constant, 16 bits per channel |
| bit_cycles | output | 48 | Bit period in input clocks, 24 bits per channel |

## Verification
Register writes, pointer moves, resets, rx latching and status changes take effect at the clock edge that ends the access. Read data and line parameters are combinational from that state, so their new values show one edge after the stimulus. `tx_valid` and `tx_byte` are registered and appear in the cycle after the data write. The bench drives each access from one falling edge to the next. It captures `bus_rdata` shortly after driving a read, before the edge that moves the pointer. It samples every other result at the falling edge after the edge in which the result becomes due.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int DW     = 8;
  localparam int NREG   = 16;
  localparam int PTR_W  = $clog2(NREG);
  localparam int NCH    = 2;
  localparam int TC_W   = 2 * DW;
  localparam int LEN_W  = 4;
  localparam int PS_W   = 7;
  localparam int BC_W   = TC_W + 2 + 6;

  localparam logic [PTR_W-1:0] REG_RXCFG  = PTR_W'(3);
  localparam logic [PTR_W-1:0] REG_FMT    = PTR_W'(4);
  localparam logic [PTR_W-1:0] REG_TXCFG  = PTR_W'(5);
  localparam logic [PTR_W-1:0] REG_RSTCTL = PTR_W'(9);
  localparam logic [PTR_W-1:0] REG_TCLO   = PTR_W'(12);
  localparam logic [PTR_W-1:0] REG_TCHI   = PTR_W'(13);

  localparam logic [DW-1:0] STAT0_RST = 8'h44;
  localparam logic [DW-1:0] STAT1_RST = 8'h07;

  localparam logic [2:0] CMD_POINT_HIGH = 3'b001;

  // reset value of each write register
  function automatic logic [DW-1:0] wr_reset_val(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] char_bits(input logic [1:0] code);
    case (code)
      2'b00:   return LEN_W'(5);
      2'b01:   return LEN_W'(7);
      2'b10:   return LEN_W'(6);
      default: return LEN_W'(8);
    endcase
  endfunction

  function automatic logic [PS_W-1:0] prescale_of(input logic [1:0] code);
    case (code)
      2'b00:   return PS_W'(1);
      2'b01:   return PS_W'(16);
      2'b10:   return PS_W'(32);
      default: return PS_W'(64);
    endcase
  endfunction

  // input clocks per bit: clock halved, divided by (tc+2), then by prescale
  function automatic logic [BC_W-1:0] bit_period(input logic [TC_W-1:0] tc,
                                                 input logic [PS_W-1:0] ps);
    logic [BC_W-1:0] span;
    span = BC_W'(tc) + BC_W'(2);
    return (span * BC_W'(ps)) << 1;
  endfunction
endpackage

// File: rtl/serreg_ptr.sv
module serreg_ptr
  import serreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_rst,
  input  logic             ctrl_wr,
  input  logic             ctrl_rd,
  input  logic [DW-1:0]    wdata,
  output logic [PTR_W-1:0] ptr,
  output logic             reg_wr
);
  logic [PTR_W-1:0] ptr_q;
  logic             at_zero;
  logic             point_high;

  assign at_zero    = (ptr_q == '0);
  assign point_high = (wdata[5:3] == CMD_POINT_HIGH);
  assign reg_wr     = ctrl_wr && !at_zero;
  assign ptr        = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (chan_rst) begin
      ptr_q <= '0;
    end else if (ctrl_wr) begin
      if (at_zero) ptr_q <= {point_high, wdata[2:0]};
      else         ptr_q <= '0;
    end else if (ctrl_rd) begin
      ptr_q <= '0;
    end
  end

  AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_wr || ctrl_rd) && !at_zero) |=> (ptr_q == '0)); // R3

  AST_PTR_HIGH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && at_zero && !chan_rst && point_high) |=> ptr_q[PTR_W-1]); // R2
endmodule

// File: rtl/serreg_lineparam.sv
module serreg_lineparam
  import serreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     fmt_reg,
  input  logic [DW-1:0]     txcfg_reg,
  input  logic [DW-1:0]     tc_lo,
  input  logic [DW-1:0]     tc_hi,
  output logic [LEN_W-1:0]  char_len,
  output logic              par_en,
  output logic              par_even,
  output logic              stop2,
  output logic [PS_W-1:0]   prescale,
  output logic [TC_W-1:0]   time_const,
  output logic [BC_W-1:0]   bit_cycles
);
  assign char_len   = char_bits(txcfg_reg[6:5]);
  assign par_en     = fmt_reg[0];
  assign par_even   = fmt_reg[1];
  assign stop2      = (fmt_reg[3:2] == 2'b11);
  assign prescale   = prescale_of(fmt_reg[7:6]);
  assign time_const = {tc_hi, tc_lo};
  assign bit_cycles = bit_period(time_const, prescale);

  AST_CHAR_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_len >= LEN_W'(5)) && (char_len <= LEN_W'(8))); // R9

  AST_PRESCALE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(prescale) == 1); // R11
endmodule

// File: rtl/serreg_chan.sv
module serreg_chan
  import serreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_rst,
  input  logic             ctrl_wr,
  input  logic             ctrl_rd,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ctrl_rdata,
  output logic [DW-1:0]    data_rdata,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  output logic             rx_ready,
  input  logic             brk_in,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_byte,
  output logic [1:0]       rst_req,
  output logic [DW-1:0]    fmt_reg,
  output logic [DW-1:0]    txcfg_reg,
  output logic [DW-1:0]    tc_lo,
  output logic [DW-1:0]    tc_hi
);
  logic [PTR_W-1:0] ptr;
  logic             reg_wr;
  logic [DW-1:0]    wr_q [NREG];
  logic [DW-1:0]    stat0_q;
  logic [DW-1:0]    stat1_q;
  logic [DW-1:0]    rx_hold_q;
  logic             tx_valid_q;
  logic [DW-1:0]    tx_byte_q;
  logic             rx_take;
  logic             tx_en;

  serreg_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_rst (chan_rst),
    .ctrl_wr  (ctrl_wr),
    .ctrl_rd  (ctrl_rd),
    .wdata    (wdata),
    .ptr      (ptr),
    .reg_wr   (reg_wr)
  );

  assign tx_en     = wr_q[REG_TXCFG][3];
  assign rx_ready  = wr_q[REG_RXCFG][0] && !stat0_q[0];
  assign rx_take   = rx_valid && rx_ready;
  assign rst_req   = (reg_wr && ptr == REG_RSTCTL) ? wdata[7:6] : 2'b00;

  assign fmt_reg   = wr_q[REG_FMT];
  assign txcfg_reg = wr_q[REG_TXCFG];
  assign tc_lo     = wr_q[REG_TCLO];
  assign tc_hi     = wr_q[REG_TCHI];
  assign tx_valid  = tx_valid_q;
  assign tx_byte   = tx_byte_q;
  assign data_rdata = rx_hold_q;

  always_comb begin
    case (ptr)
      PTR_W'(0): ctrl_rdata = stat0_q;
      PTR_W'(1): ctrl_rdata = stat1_q;
      REG_TCLO:  ctrl_rdata = wr_q[REG_TCLO];
      REG_TCHI:  ctrl_rdata = wr_q[REG_TCHI];
      default:   ctrl_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= wr_reset_val(i);
      stat0_q    <= STAT0_RST;
      stat1_q    <= STAT1_RST;
      rx_hold_q  <= '0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else if (chan_rst) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= wr_reset_val(i);
      stat0_q    <= STAT0_RST;
      stat1_q    <= STAT1_RST;
      rx_hold_q  <= '0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      if (reg_wr) wr_q[ptr] <= wdata;
      tx_valid_q <= data_wr && tx_en;
      if (data_wr) begin
        tx_byte_q  <= wdata;
        stat0_q[2] <= 1'b1;
        stat1_q[0] <= 1'b1;
      end
      if (data_rd) stat0_q[0] <= 1'b0;
      if (rx_take) begin
        rx_hold_q  <= rx_byte;
        stat0_q[0] <= 1'b1;
      end
      if (brk_in) stat0_q[7] <= 1'b1;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0_q[0] && !data_rd && !chan_rst) |=> (stat0_q[0] && $stable(rx_hold_q))); // R7

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_q |-> ($past(data_wr) && $past(tx_en))); // R8

  AST_BREAK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0_q[7] && !chan_rst) |=> stat0_q[7]); // R12

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (ptr == '0 && stat1_q == STAT1_RST && wr_q[REG_FMT] == 8'h04
                  && wr_q[REG_TCLO] == '0 && !tx_valid_q)); // R5
endmodule

// File: rtl/serreg_top.sv
module serreg_top
  import serreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NCH-1:0]       rx_valid,
  input  logic [NCH*DW-1:0]    rx_byte,
  output logic [NCH-1:0]       rx_ready,
  input  logic [NCH-1:0]       brk_in,
  output logic [NCH-1:0]       tx_valid,
  output logic [NCH*DW-1:0]    tx_byte,
  output logic [NCH*LEN_W-1:0] char_len,
  output logic [NCH-1:0]       par_en,
  output logic [NCH-1:0]       par_even,
  output logic [NCH-1:0]       stop2,
  output logic [NCH*PS_W-1:0]  prescale,
  output logic [NCH*TC_W-1:0]  time_const,
  output logic [NCH*BC_W-1:0]  bit_cycles
);
  logic          is_data;
  logic [DW-1:0] ctrl_rdata [NCH];
  logic [DW-1:0] data_rdata [NCH];
  logic [1:0]    rst_req    [NCH];
  logic [NCH-1:0] chan_rst;
  logic [NCH-1:0] hit;

  assign is_data = bus_addr[0];

  // reset field bit c resets channel c, whichever channel carried the write
  always_comb begin
    chan_rst = '0;
    for (int s = 0; s < NCH; s++) chan_rst = chan_rst | rst_req[s];
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chan
      logic [DW-1:0] fmt_reg, txcfg_reg, tc_lo, tc_hi;

      assign hit[c] = bus_sel && (bus_addr[1] == 1'(c));

      serreg_chan u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_rst   (chan_rst[c]),
        .ctrl_wr    (hit[c] && bus_we && !is_data),
        .ctrl_rd    (hit[c] && !bus_we && !is_data),
        .data_wr    (hit[c] && bus_we && is_data),
        .data_rd    (hit[c] && !bus_we && is_data),
        .wdata      (bus_wdata),
        .ctrl_rdata (ctrl_rdata[c]),
        .data_rdata (data_rdata[c]),
        .rx_valid   (rx_valid[c]),
        .rx_byte    (rx_byte[c*DW +: DW]),
        .rx_ready   (rx_ready[c]),
        .brk_in     (brk_in[c]),
        .tx_valid   (tx_valid[c]),
        .tx_byte    (tx_byte[c*DW +: DW]),
        .rst_req    (rst_req[c]),
        .fmt_reg    (fmt_reg),
        .txcfg_reg  (txcfg_reg),
        .tc_lo      (tc_lo),
        .tc_hi      (tc_hi)
      );

      serreg_lineparam u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_reg    (fmt_reg),
        .txcfg_reg  (txcfg_reg),
        .tc_lo      (tc_lo),
        .tc_hi      (tc_hi),
        .char_len   (char_len[c*LEN_W +: LEN_W]),
        .par_en     (par_en[c]),
        .par_even   (par_even[c]),
        .stop2      (stop2[c]),
        .prescale   (prescale[c*PS_W +: PS_W]),
        .time_const (time_const[c*TC_W +: TC_W]),
        .bit_cycles (bit_cycles[c*BC_W +: BC_W])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < NCH; s++)
      if (bus_addr[1] == 1'(s))
        bus_rdata = is_data ? data_rdata[s] : ctrl_rdata[s];
  end

  AST_ONE_CHANNEL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R1
endmodule

// File: tb/serreg_top_tb.sv
module serreg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  rx_valid = '0;
  logic [15:0] rx_byte = '0;
  logic [1:0]  rx_ready;
  logic [1:0]  brk_in = '0;
  logic [1:0]  tx_valid;
  logic [15:0] tx_byte;
  logic [7:0]  char_len;
  logic [1:0]  par_en, par_even, stop2;
  logic [13:0] prescale;
  logic [31:0] time_const;
  logic [47:0] bit_cycles;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serreg_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .brk_in(brk_in), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .stop2(stop2), .prescale(prescale), .time_const(time_const),
    .bit_cycles(bit_cycles)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cycles(input int tc, input int code);
    int ps;
    ps = (code == 0) ? 1 : (1 << (code + 3));
    return 32'((tc + 2) * ps * 2);
  endfunction

  task automatic bus_wr(input int ch, input bit data_port, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = {1'(ch), data_port}; bus_wdata = v;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input int ch, input bit data_port, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = {1'(ch), data_port};
    #2 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic reg_write(input int ch, input int n, input logic [7:0] v);
    bus_wr(ch, 0, (n >= 8) ? (8'h08 | 8'(n % 8)) : 8'(n));
    bus_wr(ch, 0, v);
  endtask

  task automatic reg_read(input int ch, input int n, output logic [7:0] v);
    if (n != 0) bus_wr(ch, 0, (n >= 8) ? (8'h08 | 8'(n % 8)) : 8'(n));
    bus_rd(ch, 0, v);
  endtask

  task automatic rx_pulse(input int ch, input logic [7:0] v);
    @(negedge clk);
    rx_valid[ch] = 1; rx_byte[ch*8 +: 8] = v;
    @(negedge clk);
    rx_valid[ch] = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    reg_read(0, 0, v); check("R5 rr0 ch0", v, 8'h44);
    reg_read(1, 1, v); check("R5 rr1 ch1", v, 8'h07);
    check("R5 char_len", char_len[3:0], 5);
    check("R5 stop2", stop2[0], 0);
    check("R5 par_en", par_en[0], 0);
    check("R5 prescale", prescale[6:0], 1);
    check("R5 bit_cycles", bit_cycles[23:0], 4);
    check("R5 rx_ready", rx_ready, 0);
    check("R5 tx_valid", tx_valid, 0);
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    reg_write(1, 12, 8'h34);
    reg_write(1, 13, 8'h12);
    reg_read(1, 12, v); check("R2 R6 rr12", v, 8'h34);
    reg_read(1, 13, v); check("R6 rr13", v, 8'h12);
    check("R6 time_const ch1", time_const[31:16], 16'h1234);
    check("R1 time_const ch0 untouched", time_const[15:0], 0);
  endtask

  task automatic t_ptr_return;
    logic [7:0] v;
    bus_wr(0, 0, 8'h03);
    bus_rd(0, 0, v); check("R3 rr3 zero", v, 0);
    bus_rd(0, 0, v); check("R3 read returns to rr0", v, 8'h44);
    bus_wr(0, 0, 8'h05);
    bus_wr(0, 0, 8'h60);
    bus_rd(0, 0, v); check("R3 write returns to rr0", v, 8'h44);
    check("R9 char_len 8", char_len[3:0], 8);
  endtask

  task automatic t_line;
    reg_write(1, 4, 8'hCF);
    check("R10 par_en", par_en[1], 1);
    check("R10 par_even", par_even[1], 1);
    check("R10 stop2", stop2[1], 1);
    check("R11 prescale 64", prescale[13:7], 64);
    check("R11 bit_cycles 64", bit_cycles[47:24], exp_cycles(16'h1234, 3));
    reg_write(1, 4, 8'h41);
    check("R10 odd parity", {par_en[1], par_even[1], stop2[1]}, 3'b100);
    check("R11 prescale 16", prescale[13:7], 16);
    check("R11 bit_cycles 16", bit_cycles[47:24], exp_cycles(16'h1234, 1));
    reg_write(1, 4, 8'h88);
    check("R10 stop code 10 single", stop2[1], 0);
    check("R11 prescale 32", prescale[13:7], 32);
    reg_write(1, 5, 8'h20); check("R9 len 7", char_len[7:4], 7);
    reg_write(1, 5, 8'h40); check("R9 len 6", char_len[7:4], 6);
    reg_write(1, 5, 8'h00); check("R9 len 5", char_len[7:4], 5);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    rx_pulse(0, 8'h11);
    reg_read(0, 0, v); check("R7 rx ignored when disabled", v, 8'h44);
    reg_write(0, 3, 8'h01);
    check("R7 rx_ready enabled", rx_ready[0], 1);
    rx_pulse(0, 8'hA5);
    check("R7 rx_ready after take", rx_ready[0], 0);
    reg_read(0, 0, v); check("R7 rr0 rx avail", v, 8'h45);
    rx_pulse(0, 8'h5A);
    bus_rd(0, 1, v); check("R7 data read keeps first byte", v, 8'hA5);
    reg_read(0, 0, v); check("R7 rr0 cleared", v, 8'h44);
    check("R7 rx_ready again", rx_ready[0], 1);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    bus_wr(1, 1, 8'h3C);
    check("R8 no tx when disabled", tx_valid[1], 0);
    reg_write(1, 5, 8'h68);
    bus_wr(1, 1, 8'hC3);
    check("R8 tx_valid", tx_valid[1], 1);
    check("R8 tx_byte", tx_byte[15:8], 8'hC3);
    @(negedge clk);
    check("R8 tx_valid one cycle", tx_valid[1], 0);
    reg_read(1, 0, v); check("R8 tx empty", v[2], 1);
    reg_read(1, 1, v); check("R8 all sent", v[0], 1);
  endtask

  task automatic t_break;
    logic [7:0] v;
    @(negedge clk); brk_in[0] = 1;
    @(negedge clk); brk_in[0] = 0;
    reg_read(0, 0, v); check("R12 break set", v, 8'hC4);
    repeat (4) @(negedge clk);
    reg_read(0, 0, v); check("R12 break sticky", v, 8'hC4);
  endtask

  task automatic t_reset_cmd;
    logic [7:0] v;
    reg_write(0, 12, 8'h55);
    reg_write(0, 9, 8'h40);
    reg_read(0, 0, v); check("R4 ch0 reset rr0", v, 8'h44);
    check("R4 ch0 rx cfg reset", rx_ready[0], 0);
    check("R4 ch0 tc reset", time_const[15:0], 0);
    check("R4 ch1 kept", time_const[31:16], 16'h1234);
    reg_write(0, 12, 8'h55);
    reg_write(0, 9, 8'h80);
    check("R4 ch1 reset by ch0 write", time_const[31:16], 0);
    check("R4 ch1 len reset", char_len[7:4], 5);
    check("R4 ch0 kept", time_const[15:0], 16'h0055);
    reg_write(1, 12, 8'h77);
    reg_write(1, 9, 8'h00);
    check("R4 no reset on 00", time_const[31:16], 16'h0077);
    reg_write(1, 9, 8'hC0);
    check("R4 both reset ch0", time_const[15:0], 0);
    check("R4 both reset ch1", time_const[31:16], 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pointer();
    t_ptr_return();
    t_line();
    t_rx();
    t_tx();
    t_break();
    t_reset_cmd();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule